// File: doc/BRIEF.md
# Eight-Channel Pin Interrupt Controller

This block watches a vector of asynchronous input channels, eight by default, and raises one interrupt request line per channel. Each channel first passes through a two-flop synchronizer. Its synchronized value is then compared with the value it had one cycle earlier, which yields a rising-edge event and a falling-edge event per channel. A per-channel state machine turns those events, or the qualified input level, into a pending bit. The pending vector drives the interrupt outputs directly.

Software controls the block through a small word-addressed register port. Writes take effect on the clock edge. Reads are combinational from the address. A mode register chooses edge or level detection for each channel. There are two enable vectors, and each one can be changed only through a write-one-to-set alias and a write-one-to-clear alias. The first vector enables rising edges in edge mode and enables the channel in level mode. The second vector enables falling edges in edge mode and selects the active polarity in level mode. Latched rise flags, latched fall flags and the pending status can all be cleared by writing ones.

Top module: `pin_irq_ctrl`

Each channel has its own state machine with three states:

- CH_QUIET: nothing is pending.
- CH_EDGE_HELD: an edge interrupt is latched.
- CH_LEVEL_ON: a level interrupt is asserted.

Its transitions are:

- QUIET to EDGE_HELD: an enabled edge in edge mode.
- EDGE_HELD to QUIET: a status clear with no new enabled edge in the same cycle.
- QUIET to LEVEL_ON: level mode, enabled, and the qualified level is active.
- LEVEL_ON to QUIET: the level drops, the channel is disabled, or the channel returns to edge mode with no enabled edge.
- EDGE_HELD to LEVEL_ON or QUIET: the channel is switched to level mode; the state then follows the qualified level.

## Requirements
- R1: After reset every register reads 0 and every irq bit is 0.
- R2: The mode register sits at word address 0 and holds one bit per channel (bit n is channel n). It reads back what was written. A 0 bit selects edge detection and a 1 bit selects level detection.
- R3: Writing ones to address 2 sets those bits of the rising enable, which reads at address 1. Writing ones to address 5 sets those bits of the second enable, which reads at address 4. Zero bits leave the enables unchanged. Direct writes to addresses 1 and 4 are ignored, and both aliases read 0.
- R4: Writing ones to address 3 clears those rising enable bits. Writing ones to address 6 clears those second enable bits.
- R5: The rise flags at address 7 latch every synchronized rising edge of a channel, whatever its enables are. Writing 1 to a bit clears that flag.
- R6: The fall flags at address 8 latch every synchronized falling edge, whatever the enables are. Writing 1 to a bit clears that flag.
- R7: In edge mode, the pending bit (status at address 9, and the irq output) sets on a rising edge when the rising enable bit is 1. It also sets on a falling edge when the second enable bit is 1. It stays set until a 1 is written to it. Edges that are not enabled do not set it.
- R8: In level mode with the rising enable bit set, the pending bit follows the input level. The level is active high when the second enable bit is 1 and active low when it is 0. Writing 1 to status does not remove an active level.
- R9: If a hardware edge sets a flag in the same cycle as software writes 1 to clear it, the flag ends up set.
- R10: An input change reaches the flags and the pending bits on the third rising clock edge after it is applied: two synchronizer stages and one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| pin_in | input | N_CH | Asynchronous channel inputs |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Word address of the register |
| bus_wdata | input | N_CH | Write data, bit n for channel n |
| bus_rdata | output | N_CH | Combinational read data for bus_addr |
| irq | output | N_CH | Per-channel interrupt request (pending vector) |

## Verification
The assertions assume the following about the inputs:

- rst_n is asserted at start-up.
- bus_addr is stable and meaningful whenever bus_wr is high.
- Each write is one cycle long and touches one register.

The assertions also treat the synchronizer outputs as the only source of edge events. They take no account of metastable values on pin_in.

The bench respects these assumptions:

- Every input is driven on the falling clock edge.
- Each write strobe lasts one cycle.
- Every channel change is held for at least four cycles before outputs are sampled.
- The one deliberate collision, where an edge and a clear meet in the same cycle, is placed exactly on the third rising edge after the input changes.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        SEL_MODE      = 4'd0,
        SEL_REN       = 4'd1,
        SEL_REN_SET   = 4'd2,
        SEL_REN_CLR   = 4'd3,
        SEL_AEN       = 4'd4,
        SEL_AEN_SET   = 4'd5,
        SEL_AEN_CLR   = 4'd6,
        SEL_RFLAG     = 4'd7,
        SEL_FFLAG     = 4'd8,
        SEL_STATUS    = 4'd9
    } reg_sel_e;

    typedef enum logic [1:0] {
        CH_QUIET     = 2'd0,
        CH_EDGE_HELD = 2'd1,
        CH_LEVEL_ON  = 2'd2
    } chan_state_e;

endpackage

// File: rtl/pin_sync_edge.sv
module pin_sync_edge #(
    parameter int N_CH   = 8,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] pin_in,
    output logic [N_CH-1:0] sync_val,
    output logic [N_CH-1:0] rise_ev,
    output logic [N_CH-1:0] fall_ev
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][N_CH-1:0] chain_q;
    logic [N_CH-1:0]             prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= pin_in;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain_q[LAST];
    end

    assign sync_val = chain_q[LAST];
    assign rise_ev  = chain_q[LAST] & ~prev_q;
    assign fall_ev  = ~chain_q[LAST] & prev_q;
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
    import pin_irq_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_CH-1:0]   bus_wdata,
    output logic [N_CH-1:0]   bus_rdata,
    input  logic [N_CH-1:0]   rise_ev,
    input  logic [N_CH-1:0]   fall_ev,
    input  logic [N_CH-1:0]   pend,
    output logic [N_CH-1:0]   mode_q,
    output logic [N_CH-1:0]   rise_en_q,
    output logic [N_CH-1:0]   alt_en_q,
    output logic [N_CH-1:0]   rise_flag_q,
    output logic [N_CH-1:0]   fall_flag_q,
    output logic [N_CH-1:0]   pend_clr
);
    reg_sel_e        sel;
    logic [N_CH-1:0] wr_mask;
    logic            wr_mode, wr_rset, wr_rclr, wr_aset, wr_aclr;
    logic            wr_rflag, wr_fflag, wr_stat;

    assign sel     = reg_sel_e'(bus_addr);
    assign wr_mask = bus_wr ? bus_wdata : '0;

    always_comb begin
        wr_mode  = 1'b0;
        wr_rset  = 1'b0;
        wr_rclr  = 1'b0;
        wr_aset  = 1'b0;
        wr_aclr  = 1'b0;
        wr_rflag = 1'b0;
        wr_fflag = 1'b0;
        wr_stat  = 1'b0;
        if (bus_wr) begin
            unique case (sel)
                SEL_MODE:    wr_mode  = 1'b1;
                SEL_REN_SET: wr_rset  = 1'b1;
                SEL_REN_CLR: wr_rclr  = 1'b1;
                SEL_AEN_SET: wr_aset  = 1'b1;
                SEL_AEN_CLR: wr_aclr  = 1'b1;
                SEL_RFLAG:   wr_rflag = 1'b1;
                SEL_FFLAG:   wr_fflag = 1'b1;
                SEL_STATUS:  wr_stat  = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q      <= '0;
            rise_en_q   <= '0;
            alt_en_q    <= '0;
            rise_flag_q <= '0;
            fall_flag_q <= '0;
        end else begin
            if (wr_mode) mode_q <= bus_wdata;
            if (wr_rset) rise_en_q <= rise_en_q | bus_wdata;
            if (wr_rclr) rise_en_q <= rise_en_q & ~bus_wdata;
            if (wr_aset) alt_en_q  <= alt_en_q | bus_wdata;
            if (wr_aclr) alt_en_q  <= alt_en_q & ~bus_wdata;
            rise_flag_q <= (rise_flag_q & ~(wr_rflag ? wr_mask : '0)) | rise_ev;
            fall_flag_q <= (fall_flag_q & ~(wr_fflag ? wr_mask : '0)) | fall_ev;
        end
    end

    assign pend_clr = wr_stat ? wr_mask : '0;

    always_comb begin
        unique case (sel)
            SEL_MODE:   bus_rdata = mode_q;
            SEL_REN:    bus_rdata = rise_en_q;
            SEL_AEN:    bus_rdata = alt_en_q;
            SEL_RFLAG:  bus_rdata = rise_flag_q;
            SEL_FFLAG:  bus_rdata = fall_flag_q;
            SEL_STATUS: bus_rdata = pend;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pin_chan_fsm.sv
module pin_chan_fsm
    import pin_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_mode,
    input  logic rise_en,
    input  logic alt_en,
    input  logic rise_ev,
    input  logic fall_ev,
    input  logic sync_val,
    input  logic clr,
    output logic pend
);
    chan_state_e state_q, state_d;
    logic        edge_hit, lvl_act;

    assign edge_hit = (rise_ev & rise_en) | (fall_ev & alt_en);
    assign lvl_act  = rise_en & (alt_en ? sync_val : ~sync_val);

    always_comb begin
        state_d = state_q;
        if (lvl_mode) begin
            state_d = lvl_act ? CH_LEVEL_ON : CH_QUIET;
        end else begin
            unique case (state_q)
                CH_QUIET:     state_d = edge_hit ? CH_EDGE_HELD : CH_QUIET;
                CH_EDGE_HELD: state_d = (clr && !edge_hit) ? CH_QUIET : CH_EDGE_HELD;
                CH_LEVEL_ON:  state_d = edge_hit ? CH_EDGE_HELD : CH_QUIET;
                default:      state_d = CH_QUIET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            CH_QUIET:     pend = 1'b0;
            CH_EDGE_HELD: pend = 1'b1;
            CH_LEVEL_ON:  pend = 1'b1;
            default:      pend = 1'b0;
        endcase
    end
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
    import pin_irq_pkg::*;
#(
    parameter int N_CH        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   pin_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_CH-1:0]   bus_wdata,
    output logic [N_CH-1:0]   bus_rdata,
    output logic [N_CH-1:0]   irq
);
    logic [N_CH-1:0] sync_val, rise_ev, fall_ev;
    logic [N_CH-1:0] mode_q, rise_en_q, alt_en_q;
    logic [N_CH-1:0] rise_flag_q, fall_flag_q;
    logic [N_CH-1:0] pend, pend_clr;

    pin_sync_edge #(.N_CH(N_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .sync_val (sync_val),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev)
    );

    pin_irq_regs #(.N_CH(N_CH)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .rise_ev     (rise_ev),
        .fall_ev     (fall_ev),
        .pend        (pend),
        .mode_q      (mode_q),
        .rise_en_q   (rise_en_q),
        .alt_en_q    (alt_en_q),
        .rise_flag_q (rise_flag_q),
        .fall_flag_q (fall_flag_q),
        .pend_clr    (pend_clr)
    );

    genvar c;
    generate
        for (c = 0; c < N_CH; c++) begin : g_chan
            pin_chan_fsm u_fsm (
                .clk      (clk),
                .rst_n    (rst_n),
                .lvl_mode (mode_q[c]),
                .rise_en  (rise_en_q[c]),
                .alt_en   (alt_en_q[c]),
                .rise_ev  (rise_ev[c]),
                .fall_ev  (fall_ev[c]),
                .sync_val (sync_val[c]),
                .clr      (pend_clr[c]),
                .pend     (pend[c])
            );
        end
    endgenerate

    assign irq = pend;
endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk
    import pin_irq_pkg::*;
#(
    parameter int N_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N_CH-1:0]   bus_wdata,
    input logic [N_CH-1:0]   irq,
    input logic [N_CH-1:0]   sync_val,
    input logic [N_CH-1:0]   rise_ev,
    input logic [N_CH-1:0]   mode_q,
    input logic [N_CH-1:0]   rise_en_q,
    input logic [N_CH-1:0]   alt_en_q,
    input logic [N_CH-1:0]   rise_flag_q
);
    logic [N_CH-1:0] qual_lvl;
    assign qual_lvl = ~(sync_val ^ alt_en_q);

    a_r3_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_REN_SET) |=>
        ((rise_en_q & $past(bus_wdata)) == $past(bus_wdata)));

    a_r4_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_REN_CLR) |=>
        ((rise_en_q & $past(bus_wdata)) == '0));

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == SEL_RFLAG) |=>
        ((rise_flag_q & $past(rise_flag_q)) == $past(rise_flag_q)));

    a_r9_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_ev != '0) |=>
        ((rise_flag_q & $past(rise_ev)) == $past(rise_ev)));

    a_r8_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != '0) |=>
        (((irq ^ $past(qual_lvl)) & $past(mode_q) & $past(rise_en_q)) == '0));
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.N_CH(N_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .irq         (irq),
    .sync_val    (sync_val),
    .rise_ev     (rise_ev),
    .mode_q      (mode_q),
    .rise_en_q   (rise_en_q),
    .alt_en_q    (alt_en_q),
    .rise_flag_q (rise_flag_q)
);

// File: tb/pin_irq_ctrl_bench.sv
module pin_irq_ctrl_bench;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_in = '0;
    logic         bus_wr = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pin_irq_ctrl #(.N_CH(N)) u_pin_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_pin(input int ch, input logic v);
        @(negedge clk);
        pin_in[ch] = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [N-1:0] d;
        for (int a = 0; a < 10; a++) begin
            rd(a[3:0], d);
            chk("R1", $sformatf("reg%0d after reset", a), d, '0);
        end
        chk("R1", "irq after reset", irq, '0);
    endtask

    task automatic t_mode();
        logic [N-1:0] d;
        wr(4'd0, 8'hA5); rd(4'd0, d);
        chk("R2", "mode readback", d, 8'hA5);
        wr(4'd0, 8'h00); rd(4'd0, d);
        chk("R2", "mode cleared", d, 8'h00);
    endtask

    task automatic t_enables();
        logic [N-1:0] d;
        wr(4'd2, 8'h05); wr(4'd2, 8'h00); rd(4'd1, d);
        chk("R3", "rise enable set alias", d, 8'h05);
        wr(4'd1, 8'hFF); rd(4'd1, d);
        chk("R3", "direct write ignored", d, 8'h05);
        rd(4'd2, d);
        chk("R3", "set alias reads zero", d, 8'h00);
        wr(4'd5, 8'h30); wr(4'd4, 8'hFF); rd(4'd4, d);
        chk("R3", "second enable set alias", d, 8'h30);
        wr(4'd3, 8'h01); rd(4'd1, d);
        chk("R4", "rise enable clear alias", d, 8'h04);
        wr(4'd6, 8'h30); rd(4'd4, d);
        chk("R4", "second enable clear alias", d, 8'h00);
    endtask

    task automatic t_flags();
        logic [N-1:0] d;
        wr(4'd7, 8'hFF); wr(4'd8, 8'hFF);
        set_pin(3, 1'b1);
        rd(4'd7, d); chk("R5", "rise flag on disabled ch3", d, 8'h08);
        chk("R7", "no irq for disabled edge", irq, 8'h00);
        set_pin(3, 1'b0);
        rd(4'd8, d); chk("R6", "fall flag on ch3", d, 8'h08);
        wr(4'd7, 8'h08); rd(4'd7, d); chk("R5", "rise flag cleared", d, 8'h00);
        wr(4'd8, 8'h08); rd(4'd8, d); chk("R6", "fall flag cleared", d, 8'h00);
    endtask

    task automatic t_latency();
        logic [N-1:0] d;
        @(negedge clk); pin_in[6] = 1'b1;
        @(negedge clk); @(negedge clk);
        bus_addr = 4'd7; #1 d = bus_rdata;
        chk("R10", "flag not yet set after two edges", d & 8'h40, 8'h00);
        @(negedge clk); #1 d = bus_rdata;
        chk("R10", "flag set after third edge", d & 8'h40, 8'h40);
        set_pin(6, 1'b0);
        wr(4'd7, 8'h40); wr(4'd8, 8'h40);
    endtask

    task automatic t_edge_pend();
        logic [N-1:0] d;
        set_pin(2, 1'b1);
        chk("R7", "rising edge pends ch2", irq, 8'h04);
        set_pin(2, 1'b0);
        rd(4'd9, d); chk("R7", "pending held, fall not enabled", d, 8'h04);
        wr(4'd9, 8'h04);
        chk("R7", "pending cleared by W1C", irq, 8'h00);
        wr(4'd5, 8'h04); wr(4'd3, 8'h04);
        set_pin(2, 1'b1);
        chk("R7", "rise disabled, no pend", irq, 8'h00);
        set_pin(2, 1'b0);
        chk("R7", "falling edge pends ch2", irq, 8'h04);
        wr(4'd9, 8'h04); wr(4'd6, 8'h04);
        chk("R7", "cleared after falling test", irq, 8'h00);
    endtask

    task automatic t_level();
        logic [N-1:0] d;
        wr(4'd5, 8'h02); wr(4'd0, 8'h02); wr(4'd2, 8'h02);
        repeat (3) @(negedge clk);
        chk("R8", "active high, pin low", irq, 8'h00);
        set_pin(1, 1'b1);
        chk("R8", "active high, pin high", irq, 8'h02);
        wr(4'd9, 8'h02); @(negedge clk);
        rd(4'd9, d); chk("R8", "W1C does not drop active level", d, 8'h02);
        set_pin(1, 1'b0);
        chk("R8", "level released", irq, 8'h00);
        wr(4'd6, 8'h02); repeat (2) @(negedge clk);
        chk("R8", "active low, pin low", irq, 8'h02);
        set_pin(1, 1'b1);
        chk("R8", "active low, pin high", irq, 8'h00);
        wr(4'd3, 8'h02); wr(4'd0, 8'h00); set_pin(1, 1'b0);
        wr(4'd7, 8'hFF); wr(4'd8, 8'hFF);
    endtask

    task automatic t_set_wins();
        logic [N-1:0] d;
        set_pin(4, 1'b1); set_pin(4, 1'b0);
        rd(4'd7, d); chk("R5", "ch4 rise flag primed", d, 8'h10);
        @(negedge clk); pin_in[4] = 1'b1;
        @(negedge clk); @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'd7; bus_wdata = 8'h10;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        rd(4'd7, d); chk("R9", "edge beats clear", d, 8'h10);
        wr(4'd7, 8'h10); rd(4'd7, d);
        chk("R9", "plain clear afterwards", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mode();
        t_enables();
        t_flags();
        t_latency();
        t_edge_pend();
        t_level();
        t_set_wins();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule